// File: doc/BRIEF.md
# Random Byte Queue with Fill-Level Interrupt

The block gathers bytes from an external random bit source into a 128-entry byte queue. Software drains the queue through a 32-bit register bus. Each read of the data register removes up to four bytes and packs them into one word, with the oldest byte in the lowest lane. A live fill count and a programmable threshold share one register. A sticky status flag is raised while the count is above the threshold, and it drives a level interrupt through an enable mask.

Refilling is paced. A 0-to-1 write of the enable bit opens the source port at once, and the port stays open until the queue is full. From that point the port stays shut for a fixed refill period of capacity × 8 clock cycles, and then it reopens. Clearing the enable bit shuts the port, and the bytes already stored stay in the queue. The source has a valid/ready handshake, so a byte is only ever taken when ready is high.

Top module: `entropy_fifo`

Register map, at word offsets of the byte address. Only accesses with `be_i == 4'hF` act; any other access is ignored.
- 0x00: control. Bit 0 is the enable.
- 0x04: level. Bits [7:0] hold the fill count and are read-only. Bits [23:16] hold the threshold.
- 0x08: status. Bit 0 is the over-threshold flag, cleared by writing 1.
- 0x0C: interrupt enable. Bit 0 masks the status flag onto the interrupt.
- 0x10: data. A read pops bytes from the queue.

## Requirements
- R1: After reset the control, level, status and interrupt-enable registers read 0, `irq_o` is 0 and `src_ready_o` is 0.
- R2: `src_ready_o` is 1 only while the block is enabled, inside a refill window and holding fewer than 128 bytes. Every byte taken with `src_valid_i & src_ready_o` is stored, and the queue holds at most 128 bytes.
- R3: A read of data (0x10) removes min(count, 4) bytes. The first byte removed appears in bits [7:0], the next in [15:8], and so on. Lanes with no byte read 0. A read of an empty queue returns 0 and leaves the count at 0.
- R4: Level bits [7:0] show the number of bytes held, updated on the edge of every push and pop.
- R5: Status bit 0 becomes 1 on the edge after the fill count is strictly greater than level bits [23:16]. A count equal to the threshold does not set it.
- R6: Writing 1 to status bit 0 clears it on that write's edge. If the count is still above the threshold, the bit is set again on the following edge.
- R7: `irq_o` is 1 exactly when status bit 0 and interrupt-enable bit 0 are both 1.
- R8: Writing control bit 0 from 0 to 1 opens a refill window at once. Writing it from 1 to 0 shuts the port. Writing the value it already holds changes nothing, and in particular does not reopen a closed window.
- R9: The queue reaches 128 bytes on a push edge. From that edge, `src_ready_o` stays 0 for 1024 cycles (128 × 8). It then reopens, provided the queue has room.
- R10: An access with `be_i != 4'hF` has no effect. Its writes change no register, and its reads return 0 and remove no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte address |
| be_i | input | 4 | Byte enables; only 4'hF is valid |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of the read |
| src_valid_i | input | 1 | Source byte valid |
| src_data_i | input | 8 | Source byte |
| src_ready_o | output | 1 | Block accepts the source byte |
| irq_o | output | 1 | Level interrupt |

## Verification
Read data comes back in the same cycle as the read. A pop or push shows in the count from the next cycle. The status flag lags the count by one more edge, and the interrupt follows the flag without delay. The bench therefore drives each access just after a rising edge and samples at the falling edge. It always leaves at least one idle cycle between the last push and a status read. It reads status straight after a clear write, expecting 0, and then once more, expecting the re-set 1. The refill pause is measured as the number of rising edges without an accept between the push that fills the queue and the next accepted byte, which must equal 1024.

// File: rtl/entropy_fifo_pkg.sv
package entropy_fifo_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned LANES   = DATA_W / 8;
  localparam int unsigned THR_LSB = 16;
  localparam int unsigned STAT_W  = 1;

  typedef enum logic [2:0] {
    REG_CTRL  = 3'd0,
    REG_LEVEL = 3'd1,
    REG_STAT  = 3'd2,
    REG_IRQEN = 3'd3,
    REG_DATA  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/entropy_fifo_store.sv
// Circular byte store; DEPTH must be a power of two.
module entropy_fifo_store #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned LANES = 4,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned POP_W = $clog2(LANES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               push_i,
  input  logic [7:0]         push_data_i,
  input  logic [POP_W-1:0]   pop_n_i,
  output logic [CNT_W-1:0]   count_o,
  output logic               full_next_o,
  output logic [LANES*8-1:0] peek_o
);
  logic [7:0]       mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q, count_d;

  assign count_d     = count_q + CNT_W'(push_i) - CNT_W'(pop_n_i);
  assign full_next_o = (count_d == CNT_W'(DEPTH));
  assign count_o     = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + PTR_W'(1);
      rd_ptr_q <= rd_ptr_q + PTR_W'(pop_n_i);
      count_q  <= count_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= push_data_i;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_peek
    assign peek_o[k*8 +: 8] = mem_q[rd_ptr_q + PTR_W'(k)];
  end
endmodule

// File: rtl/entropy_fifo_packer.sv
// Chooses how many bytes a word read takes and zeroes the empty lanes.
module entropy_fifo_packer #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned LANES = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned POP_W = $clog2(LANES + 1)
) (
  input  logic [CNT_W-1:0]   count_i,
  input  logic [LANES*8-1:0] peek_i,
  output logic [POP_W-1:0]   avail_o,
  output logic [LANES*8-1:0] word_o
);
  assign avail_o = (count_i >= CNT_W'(LANES)) ? POP_W'(LANES) : POP_W'(count_i);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign word_o[k*8 +: 8] = (count_i > CNT_W'(k)) ? peek_i[k*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/entropy_fifo_pacer.sv
// Refill window control: open until full, then shut for PERIOD cycles.
module entropy_fifo_pacer #(
  parameter int unsigned PERIOD = 1024,
  localparam int unsigned TMR_W = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic start_i,
  input  logic stop_i,
  input  logic full_next_i,
  output logic filling_o
);
  localparam logic [TMR_W-1:0] LAST = TMR_W'(PERIOD - 1);

  logic             filling_q;
  logic [TMR_W-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filling_q <= 1'b0;
      tmr_q     <= '0;
    end else if (stop_i) begin
      filling_q <= 1'b0;
      tmr_q     <= '0;
    end else if (start_i) begin
      filling_q <= 1'b1;
      tmr_q     <= '0;
    end else if (en_i) begin
      if (filling_q) begin
        if (full_next_i) filling_q <= 1'b0;
        tmr_q <= '0;
      end else if (tmr_q == LAST) begin
        filling_q <= 1'b1;
        tmr_q     <= '0;
      end else begin
        tmr_q <= tmr_q + TMR_W'(1);
      end
    end
  end

  assign filling_o = filling_q;
endmodule

// File: rtl/entropy_fifo.sv
module entropy_fifo
  import entropy_fifo_pkg::*;
#(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned POP_W  = $clog2(LANES + 1),
  localparam int unsigned PERIOD = DEPTH * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              src_valid_i,
  input  logic [7:0]        src_data_i,
  output logic              src_ready_o,
  output logic              irq_o
);
  logic              acc, wr, rd;
  reg_sel_e          sel;
  logic              en_q, en_rise, en_fall, stat_clr;
  logic [CNT_W-1:0]  thr_q, count;
  logic [STAT_W-1:0] status_q, irq_en_q, stat_cond;
  logic              push, full_next, filling;
  logic [POP_W-1:0]  avail, pop_n;
  logic [DATA_W-1:0] peek, word;
  logic              unused_bits;

  assign unused_bits = ^{addr_i[1:0], wdata_i};

  assign acc = req_i & (be_i == 4'hF);
  assign wr  = acc & we_i;
  assign rd  = acc & ~we_i;
  assign sel = reg_sel_e'(addr_i[4:2]);

  assign en_rise  = wr & (sel == REG_CTRL) & wdata_i[0] & ~en_q;
  assign en_fall  = wr & (sel == REG_CTRL) & ~wdata_i[0] & en_q;
  assign stat_clr = wr & (sel == REG_STAT) & wdata_i[0];
  assign pop_n    = (rd && sel == REG_DATA) ? avail : '0;

  assign stat_cond   = STAT_W'(count > thr_q);
  assign src_ready_o = en_q & filling & (count != CNT_W'(DEPTH));
  assign push        = src_valid_i & src_ready_o;
  assign irq_o       = |(status_q & irq_en_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      thr_q    <= '0;
      irq_en_q <= '0;
      status_q <= '0;
    end else begin
      if (en_rise) en_q <= 1'b1;
      else if (en_fall) en_q <= 1'b0;
      if (wr && sel == REG_LEVEL) thr_q <= wdata_i[THR_LSB +: CNT_W];
      if (wr && sel == REG_IRQEN) irq_en_q <= wdata_i[STAT_W-1:0];
      // clear wins in its own cycle; a held condition re-sets on the next edge
      if (stat_clr) status_q <= '0;
      else          status_q <= status_q | stat_cond;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (sel)
        REG_CTRL:  rdata_o = DATA_W'(en_q);
        REG_LEVEL: rdata_o = (DATA_W'(thr_q) << THR_LSB) | DATA_W'(count);
        REG_STAT:  rdata_o = DATA_W'(status_q);
        REG_IRQEN: rdata_o = DATA_W'(irq_en_q);
        REG_DATA:  rdata_o = word;
        default:   rdata_o = '0;
      endcase
    end
  end

  entropy_fifo_store #(.DEPTH(DEPTH), .LANES(LANES)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_data_i (src_data_i),
    .pop_n_i     (pop_n),
    .count_o     (count),
    .full_next_o (full_next),
    .peek_o      (peek)
  );

  entropy_fifo_packer #(.DEPTH(DEPTH), .LANES(LANES)) u_packer (
    .count_i (count),
    .peek_i  (peek),
    .avail_o (avail),
    .word_o  (word)
  );

  entropy_fifo_pacer #(.PERIOD(PERIOD)) u_pacer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_q),
    .start_i     (en_rise),
    .stop_i      (en_fall),
    .full_next_i (full_next),
    .filling_o   (filling)
  );
endmodule

// File: rtl/entropy_fifo_chk.sv
module entropy_fifo_chk #(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [4:0]       addr_i,
  input logic [3:0]       be_i,
  input logic [31:0]      rdata_i,
  input logic             src_valid_i,
  input logic             src_ready_i,
  input logic             irq_i,
  input logic             en_i,
  input logic             clr_i,
  input logic [CNT_W-1:0] count_i,
  input logic [CNT_W-1:0] thr_i,
  input logic             status_i
);
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CNT_W'(DEPTH)); // R2
  AST_FULL_SHUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i == CNT_W'(DEPTH)) |-> !src_ready_i); // R2
  AST_OFF_SHUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !src_ready_i); // R8
  AST_NO_PHANTOM_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(src_valid_i && src_ready_i) |=> count_i <= $past(count_i)); // R4
  AST_THR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i > thr_i) && !clr_i |=> status_i); // R5
  AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !status_i); // R6
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> status_i); // R7
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == 5'h10 && count_i == '0) |-> rdata_i == 32'h0); // R3
  AST_BAD_SIZE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && be_i != 4'hF) |-> rdata_i == 32'h0); // R10
endmodule

bind entropy_fifo entropy_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .be_i        (be_i),
  .rdata_i     (rdata_o),
  .src_valid_i (src_valid_i),
  .src_ready_i (src_ready_o),
  .irq_i       (irq_o),
  .en_i        (en_q),
  .clr_i       (stat_clr),
  .count_i     (count),
  .thr_i       (thr_q),
  .status_i    (status_q[0])
);

// File: tb/entropy_fifo_bench.sv
`timescale 1ns/1ps
module entropy_fifo_bench;
  localparam int PERIOD = 1024;
  localparam logic [4:0] A_CTRL = 5'h00, A_LEVEL = 5'h04, A_STAT = 5'h08,
                         A_IRQEN = 5'h0C, A_DATA = 5'h10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [4:0] addr = '0;
  logic [3:0] be = 4'hF;
  logic [31:0] wdata = '0, rdata;
  logic src_valid = 1'b0, src_ready, irq;
  logic [7:0] src_data = 8'h07;

  int checks = 0, failures = 0;
  bit done = 0;
  int budget = 0, seq = 0, low_run = 0, gap_max = 0;
  int thr = 0;
  logic [7:0] model[$];
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  entropy_fifo u_entropy_fifo (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .rdata_o(rdata), .src_valid_i(src_valid),
    .src_data_i(src_data), .src_ready_o(src_ready), .irq_o(irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // source model
  always @(posedge clk) begin
    if (src_valid && src_ready) begin
      model.push_back(src_data);
      seq++;
      src_data <= 8'(seq * 29 + 7);
      budget--;
      if (budget <= 0) src_valid <= 1'b0;
      if (low_run > gap_max) gap_max = low_run;
      low_run = 0;
    end else begin
      low_run++;
      if (!src_valid && budget > 0) src_valid <= 1'b1;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (req && !we && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(rdata, e, t);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] b = 4'hF);
    req = 1; we = 1; addr = a; wdata = d; be = b;
    cyc(1);
    req = 0; we = 0; be = 4'hF;
  endtask

  task automatic bus_rd(input logic [4:0] a, input logic [31:0] e, input string t,
                        input logic [3:0] b = 4'hF);
    exp_q.push_back(e);
    tag_q.push_back(t);
    req = 1; we = 0; addr = a; be = b;
    cyc(1);
    req = 0; be = 4'hF;
  endtask

  function automatic logic [31:0] model_word();
    logic [31:0] w = '0;
    for (int k = 0; k < 4; k++)
      if (model.size() > 0) w[k*8 +: 8] = model.pop_front();
    return w;
  endfunction

  function automatic logic [31:0] level_exp();
    return (32'(thr) << 16) | 32'(model.size());
  endfunction

  task automatic feed(input int n);
    budget = n;
    while (budget > 0) cyc(1);
    cyc(2);
  endtask

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    check(32'(irq), 0, "R1 irq");
    check(32'(src_ready), 0, "R1 ready");
    bus_rd(A_CTRL, 0, "R1 ctrl");
    bus_rd(A_LEVEL, 0, "R1 level");
    bus_rd(A_STAT, 0, "R1 status");
    bus_rd(A_IRQEN, 0, "R1 irqen");
    // R8 disabled: ready stays low with a byte offered
    budget = 1;
    cyc(5);
    check(32'(src_ready), 0, "R8 ready while disabled");
    check(32'(model.size()), 0, "R8 no byte taken while disabled");
    thr = 4;
    bus_wr(A_LEVEL, 32'(thr) << 16);
    bus_wr(A_IRQEN, 1);
    bus_wr(A_CTRL, 1);
    while (budget > 0) cyc(1);
    feed(3);
    bus_rd(A_LEVEL, level_exp(), "R4 count after 4 pushes");
    bus_rd(A_STAT, 0, "R5 count equal to threshold");
    check(32'(irq), 0, "R7 irq low");
    feed(1);
    bus_rd(A_LEVEL, level_exp(), "R4 count after 5 pushes");
    bus_rd(A_STAT, 1, "R5 count above threshold");
    check(32'(irq), 1, "R7 irq high");
    bus_rd(A_DATA, model_word(), "R3 full word order");
    bus_rd(A_LEVEL, level_exp(), "R4 count after pop");
    bus_wr(A_STAT, 1);
    cyc(1);
    bus_rd(A_STAT, 0, "R6 cleared, condition gone");
    check(32'(irq), 0, "R7 irq after clear");
    bus_rd(A_DATA, model_word(), "R3 partial word");
    bus_rd(A_DATA, 0, "R3 empty read");
    bus_rd(A_LEVEL, level_exp(), "R3 empty read keeps count");
    // masked interrupt, W1C with condition held
    bus_wr(A_IRQEN, 0);
    thr = 0;
    bus_wr(A_LEVEL, 0);
    feed(1);
    bus_rd(A_STAT, 1, "R5 threshold zero");
    check(32'(irq), 0, "R7 masked");
    bus_wr(A_STAT, 1);
    bus_rd(A_STAT, 0, "R6 cleared on write edge");
    bus_rd(A_STAT, 1, "R6 set again next edge");
    bus_wr(A_IRQEN, 1);
    cyc(1);
    check(32'(irq), 1, "R7 unmasked");
    // R10 partial-width access
    bus_wr(A_CTRL, 0, 4'h1);
    bus_rd(A_CTRL, 1, "R10 partial write ignored");
    bus_rd(A_DATA, 0, "R10 partial read zero", 4'h3);
    bus_rd(A_LEVEL, level_exp(), "R10 partial read pops nothing");
    // fill, pause, refill
    gap_max = 0;
    budget = 128 - model.size() + 4;
    while (model.size() < 128) cyc(1);
    cyc(2);
    check(32'(src_ready), 0, "R2 ready low when full");
    bus_rd(A_LEVEL, level_exp(), "R2 holds 128");
    bus_rd(A_DATA, model_word(), "R3 word from full queue");
    bus_wr(A_CTRL, 1);
    cyc(20);
    check(32'(src_ready), 0, "R8 rewrite of 1 does not reopen");
    while (budget > 0) cyc(1);
    cyc(2);
    check(32'(gap_max), PERIOD, "R9 refill pause length");
    bus_rd(A_LEVEL, level_exp(), "R9 refilled");
    // disable
    bus_rd(A_DATA, model_word(), "R3 drain");
    bus_wr(A_CTRL, 0);
    budget = 3;
    cyc(PERIOD + 20);
    check(32'(src_ready), 0, "R8 ready low after disable");
    bus_rd(A_LEVEL, level_exp(), "R8 nothing taken after disable");
    budget = 0;
    cyc(2);
    while (model.size() > 0) bus_rd(A_DATA, model_word(), "R3 drain order");
    bus_rd(A_LEVEL, level_exp(), "R4 empty after drain");
    cyc(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(150000 * 4);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule